// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block is a clocked register bank that sits between a memory controller and the DRAM devices on a memory module. On each rising clock edge it captures the command/address inputs and drives them onto registered outputs. Two static strap inputs set how the captured bits reach the output pins. In the wide layout, 25 bits each drive one output. In the fan-out layout, 14 bits each drive two output copies, and a second strap picks one of two copy placements.

An asynchronous active-low reset clears the register and forces every output low at once. A pair of active-low chip-select inputs saves power. When both are high at a clock edge, the register does not load and the outputs keep their values. Reset overrides this hold.

The straps are meant to be tied off. Their behaviour while they change is undefined. The clock is a single-ended rising edge.

Top module: `cmd_addr_regbuf`

## Requirements
- R1: While `rst_n` is low, every bit of `q_out` is 0, and this takes effect without waiting for a clock edge.
- R2: Wide layout (`cfg_dual`=0). After a rising edge at which the gate is open, `q_out[24:0]` equals the `d_in` value sampled at that edge.
- R3: Wide layout. Bits `q_out[27:25]` are used only by the fan-out layout and are always 0.
- R4: Fan-out layout, placement A (`cfg_dual`=1, `cfg_alt`=0). Both `q_out[i]` and `q_out[14+i]` equal the captured `d_in[i]`, for i in 0..13.
- R5: Fan-out layout, placement B (`cfg_dual`=1, `cfg_alt`=1). Both `q_out[2i]` and `q_out[2i+1]` equal the captured `d_in[i]`, for i in 0..13.
- R6: In the fan-out layout, `d_in[24:14]` has no effect on `q_out`.
- R7: If `cs_a_n` and `cs_b_n` are both 1 at a rising edge, `q_out` after that edge equals its value before the edge.
- R8: If either chip-select is 0 at a rising edge, the outputs load the new data at that edge.
- R9: Reset has priority over the chip-select hold. Asserting reset while the gate is closed still drives `q_out` to 0. The cleared value is then kept by a hold after reset is released.
- R10: After reset is released, with `d_in` held at 0, `q_out` stays 0 on every following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | Static strap: 0 = 25-bit single output, 1 = 14-bit dual output |
| cfg_alt | input | 1 | Static strap: copy placement in the dual layout (0 = A, 1 = B) |
| cs_a_n | input | 1 | First active-low chip-select |
| cs_b_n | input | 1 | Second active-low chip-select |
| d_in | input | 25 | Command/address inputs |
| q_out | output | 28 | Registered outputs |

## Verification
The assertions check on every cycle that:
- reset holds the outputs at zero;
- the dual-only pins stay low in the wide layout;
- each copy pair agrees in both placements;
- a closed gate freezes the outputs;
- an open gate loads the sampled inputs in the wide layout.

Only the bench scenarios can show the following:
- that the copies land on the intended input bits;
- that the unused upper inputs are really ignored in the fan-out layout;
- that reset overrides a closed gate mid-cycle;
- that the outputs stay clean after reset exit.

// File: rtl/cmd_addr_regbuf.sv
module cmd_addr_regbuf #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_dual,
  input  logic                cfg_alt,
  input  logic                cs_a_n,
  input  logic                cs_b_n,
  input  logic [WIDE_W-1:0]   d_in,
  output logic [((WIDE_W > 2*NARROW_W) ? WIDE_W : 2*NARROW_W)-1:0] q_out
);
  localparam int OUT_W = (WIDE_W > 2*NARROW_W) ? WIDE_W : 2*NARROW_W;

  logic [WIDE_W-1:0] cap_q;
  logic [OUT_W-1:0]  wide_map, map_a, map_b;
  wire               hold = cs_a_n & cs_b_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cap_q <= '0;
    else if (!hold) cap_q <= d_in;

  always_comb begin
    wide_map = '0;
    wide_map[WIDE_W-1:0] = cap_q;
    map_a = '0;
    map_b = '0;
    for (int i = 0; i < NARROW_W; i++) begin
      map_a[i]            = cap_q[i];
      map_a[NARROW_W + i] = cap_q[i];
      map_b[2*i]          = cap_q[i];
      map_b[2*i + 1]      = cap_q[i];
    end
  end

  assign q_out = !cfg_dual ? wide_map : (cfg_alt ? map_b : map_a);
endmodule

// File: rtl/cmd_addr_regbuf_chk.sv
module cmd_addr_regbuf_chk #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int OUT_W    = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_dual,
  input logic              cfg_alt,
  input logic              cs_a_n,
  input logic              cs_b_n,
  input logic [WIDE_W-1:0] d_in,
  input logic [OUT_W-1:0]  q_out
);
  // R1
  reset_low_chk: assert property (@(posedge clk) !rst_n |-> q_out == '0);

  // R3
  wide_spare_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dual |-> q_out[OUT_W-1:WIDE_W] == '0);

  // R4
  map_a_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dual && !cfg_alt) |-> q_out[NARROW_W-1:0] == q_out[2*NARROW_W-1:NARROW_W]);

  // R5
  generate
    for (genvar i = 0; i < NARROW_W; i++) begin : g_b
      map_b_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && cfg_alt) |-> q_out[2*i] == q_out[2*i+1]);
    end
  endgenerate

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n && cs_b_n) |=> $stable(q_out));

  // R8
  gate_open_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs_a_n && cs_b_n) && !cfg_dual) |=> q_out[WIDE_W-1:0] == $past(d_in));
endmodule

bind cmd_addr_regbuf cmd_addr_regbuf_chk #(
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_alt(cfg_alt),
  .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .d_in(d_in), .q_out(q_out)
);

// File: tb/sim_cmd_addr_regbuf.sv
`timescale 1ns/1ps
module sim_cmd_addr_regbuf;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_dual = 0, cfg_alt = 0;
  logic        cs_a_n = 0, cs_b_n = 0;
  logic [24:0] d_in = '0;
  logic [27:0] q_out;
  logic [24:0] m_reg = '0;
  int checks = 0, errors = 0;

  cmd_addr_regbuf u0 (.clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_alt(cfg_alt),
                      .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .d_in(d_in), .q_out(q_out));

  always #2 clk = ~clk;

  function automatic logic [27:0] exp_out(input logic dual, input logic alt, input logic [24:0] r);
    logic [27:0] o = '0;
    if (!dual) o[24:0] = r;
    else for (int i = 0; i < 14; i++) begin
      if (alt) begin o[2*i] = r[i]; o[2*i+1] = r[i]; end
      else     begin o[i] = r[i];   o[14+i] = r[i]; end
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [27:0] exp);
    checks++;
    if (q_out !== exp) begin
      errors++;
      $display("FAIL %s: q_out=%h expected=%h", req, q_out, exp);
    end
  endtask

  task automatic step(input logic [24:0] d, input logic a, input logic b);
    @(negedge clk);
    d_in = d; cs_a_n = a; cs_b_n = b;
    @(negedge clk);
    if (!(a && b)) m_reg = d;
  endtask

  task automatic do_reset(input logic dual, input logic alt);
    @(negedge clk);
    rst_n = 0; cfg_dual = dual; cfg_alt = alt; d_in = '0; cs_a_n = 0; cs_b_n = 0;
    m_reg = '0;
    @(negedge clk);
    check("R1", 28'h0);
    rst_n = 1;
  endtask

  task automatic t_wide;
    do_reset(0, 0);
    step(25'h1FFFFFF, 0, 1); check("R2", exp_out(0, 0, m_reg));
    check("R3", {3'b000, 25'h1FFFFFF});
    step(25'h0A5A5A5, 1, 0); check("R2 R8", exp_out(0, 0, m_reg));
    step(25'h1234567, 0, 0); check("R2", exp_out(0, 0, m_reg));
  endtask

  task automatic t_dual_a;
    do_reset(1, 0);
    step(25'h0002A55, 0, 0); check("R4", exp_out(1, 0, m_reg));
    step(25'h1FFC000, 0, 0); check("R6", 28'h0);
    step(25'h1FF3FFF, 1, 0); check("R4 R6", 28'hFFFFFFF);
  endtask

  task automatic t_dual_b;
    do_reset(1, 1);
    step(25'h0001235, 0, 0); check("R5", exp_out(1, 1, m_reg));
    step(25'h1FFC001, 0, 1); check("R5 R6", 28'h0000003);
  endtask

  task automatic t_hold;
    do_reset(0, 0);
    step(25'h0F0F0F0, 0, 0);
    step(25'h1111111, 1, 1); check("R7", {3'b0, 25'h0F0F0F0});
    step(25'h0222222, 1, 1); check("R7", {3'b0, 25'h0F0F0F0});
    step(25'h0333333, 0, 1); check("R8", {3'b0, 25'h0333333});
  endtask

  task automatic t_reset_prio;
    do_reset(0, 0);
    step(25'h1ABCDEF, 0, 0);
    @(negedge clk); cs_a_n = 1; cs_b_n = 1; d_in = 25'h1555555;
    #1 rst_n = 0;
    #0.5 check("R9 R1", 28'h0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); check("R9", 28'h0);
  endtask

  task automatic t_reset_exit;
    do_reset(0, 0);
    for (int k = 0; k < 4; k++) begin
      step('0, 0, 0); check("R10", 28'h0);
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: q_out=%h expected=done", q_out);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 check("R1", 28'h0);
    t_reset_exit();
    t_wide();
    t_dual_a();
    t_dual_b();
    t_hold();
    t_reset_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule